// File: doc/BRIEF.md
# CAN Transmit Buffer Status Controller

This block keeps the per-buffer state that sits between a host register bus and the transmit side of a CAN protocol engine. It covers three transmit message buffers. For each buffer it holds an "empty" flag, an interrupt-enable bit, an abort-request bit and an abort-acknowledge bit. The host hands a buffer over for transmission by writing 1 to that buffer's empty flag, which clears the flag. The engine hands the buffer back by reporting a successful send, or an abort that completed.

From this state the block drives the outputs. Each buffer gets a "scheduled" line that tells the engine it may start transmission. Each buffer also gets a lock line that blocks host access to the message storage of a buffer that is still scheduled. A single combined transmit interrupt covers all three buffers. Two inputs override the flags: listen mode stops the host from scheduling anything, and initialization mode holds the flags at their reset value.

The host bus reads combinationally and writes on the clock edge. It has four word addresses: 0 is the empty flags, 1 is the interrupt enables, 2 is the abort requests, and 3 is the abort acknowledges, which are read-only. The data word is 8 bits wide. Bit n of each register belongs to buffer n, and bits 7:3 read as 0.

Top module: `can_txbuf_status`

## Requirements
- R1: After reset, address 0 reads 0x07 and addresses 1, 2 and 3 read 0x00. The interrupt, scheduled and lock outputs are all 0. Bits 7:3 of every read are 0.
- R2: A write to address 0 clears each empty flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. The change is visible after the write's clock edge.
- R3: An `eng_sent` pulse on bit n sets empty flag n at the next clock edge.
- R4: A write of 1 to address 2 bit n sets abort request n only if buffer n is scheduled, meaning its empty flag is 0. An `eng_aborted` pulse on bit n, while request n is pending and flag n is 0, sets flag n and sets abort-acknowledge n.
- R5: Whenever an empty flag goes from 0 to 1, for any cause, that buffer's abort request reads 0 afterwards.
- R6: A write that clears empty flag n also clears abort-acknowledge n.
- R7: While `listen_mode` is 1, writes to address 0 leave the flags unchanged, and all `tx_sched` outputs are 0.
- R8: While `init_req` and `init_ack` are both 1, the empty flags are forced to 0x07 at every clock edge, and writes to address 0 and address 2 are ignored.
- R9: `buf_locked[n]` is 1 exactly when empty flag n is 0. `tx_sched[n]` is 1 when flag n is 0 and listen mode is off.
- R10: `tx_irq` is 1 while some buffer has both its empty flag and its interrupt-enable bit at 1.
- R11: If a host clear and an engine set hit the same flag in the same cycle, the flag ends up set.
- R12: An `eng_aborted` pulse for a buffer with no pending abort request changes neither that flag nor its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address (0 flags, 1 enables, 2 abort request, 3 abort acknowledge) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| init_req | input | 1 | Initialization mode requested |
| init_ack | input | 1 | Initialization mode acknowledged |
| listen_mode | input | 1 | Listen-only mode active |
| eng_sent | input | 3 | Per-buffer pulse: message sent |
| eng_aborted | input | 3 | Per-buffer pulse: abort completed |
| tx_sched | output | 3 | Buffer scheduled for transmission |
| abort_ack | output | 3 | Abort-acknowledge bits |
| buf_locked | output | 3 | Host access to the buffer is blocked |
| tx_irq | output | 1 | Combined transmit interrupt |

## Verification
The hardest case to reach from the ports is a completed abort. It needs a buffer that is already scheduled, then an abort request that is accepted for it, and only then the engine's abort pulse. The stimulus builds this in that order and checks the flag, the acknowledge and the cleared request after each step. A second hard case is a host clear and an engine set landing in the same clock. The bench creates it by putting the write strobe and the engine pulse in the same cycle before a single edge.

// File: rtl/can_txbuf_status.sv
module can_txbuf_status #(
  parameter int NBUF = 3,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            init_req,
  input  logic            init_ack,
  input  logic            listen_mode,
  input  logic [NBUF-1:0] eng_sent,
  input  logic [NBUF-1:0] eng_aborted,
  output logic [NBUF-1:0] tx_sched,
  output logic [NBUF-1:0] abort_ack,
  output logic [NBUF-1:0] buf_locked,
  output logic            tx_irq
);
  localparam int PAD = DW - NBUF;

  logic [NBUF-1:0] empty_q, ie_q, areq_q, aack_q;
  logic [NBUF-1:0] empty_n, areq_n, aack_n;
  logic [NBUF-1:0] abort_done, set_ev, clr_ev, areq_wr;

  wire in_init = init_req & init_ack;
  wire wr_any  = bus_sel & bus_wr;
  wire wr_flag = wr_any & (bus_addr == 2'd0);
  wire wr_ie   = wr_any & (bus_addr == 2'd1);
  wire wr_areq = wr_any & (bus_addr == 2'd2);

  assign abort_done = eng_aborted & areq_q & ~empty_q;
  assign set_ev     = eng_sent | abort_done;
  assign clr_ev     = {NBUF{wr_flag & ~listen_mode & ~in_init}} & bus_wdata[NBUF-1:0] & ~set_ev;
  assign areq_wr    = {NBUF{wr_areq & ~in_init}} & bus_wdata[NBUF-1:0] & ~empty_q;

  always_comb begin
    if (in_init) begin
      empty_n = '1;
      areq_n  = '0;
      aack_n  = '0;
    end else begin
      empty_n = (empty_q | set_ev) & ~clr_ev;
      areq_n  = (areq_q | areq_wr) & ~(empty_n & ~empty_q);
      aack_n  = (aack_q & ~clr_ev) | abort_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= '1;
      ie_q    <= '0;
      areq_q  <= '0;
      aack_q  <= '0;
    end else begin
      empty_q <= empty_n;
      areq_q  <= areq_n;
      aack_q  <= aack_n;
      if (wr_ie) ie_q <= bus_wdata[NBUF-1:0];
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {{PAD{1'b0}}, empty_q};
      2'd1:    bus_rdata = {{PAD{1'b0}}, ie_q};
      2'd2:    bus_rdata = {{PAD{1'b0}}, areq_q};
      default: bus_rdata = {{PAD{1'b0}}, aack_q};
    endcase
  end

  assign buf_locked = ~empty_q;
  assign tx_sched   = listen_mode ? '0 : ~empty_q;
  assign abort_ack  = aack_q;
  assign tx_irq     = |(empty_q & ie_q);
endmodule

module can_txbuf_status_chk #(
  parameter int NBUF = 3,
  parameter int DW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_sel,
  input logic            bus_wr,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_wdata,
  input logic            init_req,
  input logic            init_ack,
  input logic            listen_mode,
  input logic [NBUF-1:0] eng_sent,
  input logic [NBUF-1:0] eng_aborted,
  input logic [NBUF-1:0] tx_sched,
  input logic [NBUF-1:0] abort_ack,
  input logic [NBUF-1:0] empty_q,
  input logic [NBUF-1:0] areq_q
);
  a_r3_sent_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_sent != '0) |=> ((empty_q & $past(eng_sent)) == $past(eng_sent)));

  a_r8_init_forces_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (init_req && init_ack) |=> (empty_q == '1));

  a_r5_set_drops_request: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((areq_q & empty_q & ~$past(empty_q)) == '0));

  a_r6_clear_drops_ack: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((abort_ack & ~empty_q & $past(empty_q)) == '0));

  a_r7_listen_no_sched: assert property (@(posedge clk) disable iff (!rst_n)
    listen_mode |-> (tx_sched == '0));

  a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == 2'd0 && !listen_mode && !(init_req && init_ack)
     && eng_sent == '0 && eng_aborted == '0)
    |=> (empty_q == ($past(empty_q) & ~$past(bus_wdata[NBUF-1:0]))));
endmodule

bind can_txbuf_status can_txbuf_status_chk #(.NBUF(NBUF), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .init_req(init_req), .init_ack(init_ack),
  .listen_mode(listen_mode), .eng_sent(eng_sent), .eng_aborted(eng_aborted),
  .tx_sched(tx_sched), .abort_ack(abort_ack), .empty_q(empty_q), .areq_q(areq_q)
);

// File: tb/sim_can_txbuf_status.sv
module sim_can_txbuf_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic init_req = 1'b0, init_ack = 1'b0, listen_mode = 1'b0;
  logic [2:0] eng_sent = 3'd0, eng_aborted = 3'd0;
  logic [2:0] tx_sched, abort_ack, buf_locked;
  logic tx_irq;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  can_txbuf_status u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .init_req(init_req), .init_ack(init_ack),
    .listen_mode(listen_mode), .eng_sent(eng_sent), .eng_aborted(eng_aborted),
    .tx_sched(tx_sched), .abort_ack(abort_ack), .buf_locked(buf_locked), .tx_irq(tx_irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] s, input logic [2:0] ab);
    eng_sent = s; eng_aborted = ab;
    tick();
    eng_sent = '0; eng_aborted = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 flags", d, 8'h07);
    rd(2'd1, d); chk("R1 enables", d, 8'h00);
    rd(2'd2, d); chk("R1 abort req", d, 8'h00);
    rd(2'd3, d); chk("R1 abort ack", d, 8'h00);
    chk("R1 outputs", {1'b0, tx_irq, tx_sched, buf_locked[1:0]}, 8'h00);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    wr(2'd0, 8'h05);
    rd(2'd0, d); chk("R2 clear", d, 8'h02);
    chk("R9 sched", {5'd0, tx_sched}, 8'h05);
    chk("R9 locked", {5'd0, buf_locked}, 8'h05);
    wr(2'd0, 8'hF8);
    rd(2'd0, d); chk("R2 zero write", d, 8'h02);
  endtask

  task automatic t_irq();
    wr(2'd1, 8'h02);
    chk("R10 irq on", {7'd0, tx_irq}, 8'h01);
    wr(2'd1, 8'h01);
    chk("R10 irq off", {7'd0, tx_irq}, 8'h00);
  endtask

  task automatic t_sent();
    logic [7:0] d;
    pulse(3'b001, 3'b000);
    rd(2'd0, d); chk("R3 sent", d, 8'h03);
    chk("R10 irq after send", {7'd0, tx_irq}, 8'h01);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    wr(2'd2, 8'h05);
    rd(2'd2, d); chk("R4 request accepted", d, 8'h04);
    pulse(3'b000, 3'b100);
    rd(2'd0, d); chk("R4 abort sets flag", d, 8'h07);
    rd(2'd3, d); chk("R4 abort ack", d, 8'h04);
    rd(2'd2, d); chk("R5 request dropped", d, 8'h00);
    wr(2'd0, 8'h04);
    rd(2'd3, d); chk("R6 ack cleared", d, 8'h00);
    rd(2'd0, d); chk("R6 flag cleared", d, 8'h03);
  endtask

  task automatic t_stray_abort();
    logic [7:0] d;
    wr(2'd0, 8'h01);
    pulse(3'b000, 3'b001);
    rd(2'd0, d); chk("R12 flag kept", d, 8'h02);
    rd(2'd3, d); chk("R12 ack kept", d, 8'h00);
    wr(2'd2, 8'h04);
    pulse(3'b101, 3'b000);
    rd(2'd0, d); chk("R3 sent two", d, 8'h07);
    rd(2'd2, d); chk("R5 request dropped on send", d, 8'h00);
  endtask

  task automatic t_listen();
    logic [7:0] d;
    wr(2'd0, 8'h01);
    chk("R9 sched before listen", {5'd0, tx_sched}, 8'h01);
    listen_mode = 1'b1;
    #1;
    chk("R7 no sched", {5'd0, tx_sched}, 8'h00);
    chk("R9 locked in listen", {5'd0, buf_locked}, 8'h01);
    wr(2'd0, 8'h06);
    rd(2'd0, d); chk("R7 write ignored", d, 8'h06);
    listen_mode = 1'b0;
    pulse(3'b001, 3'b000);
  endtask

  task automatic t_init();
    logic [7:0] d;
    init_req = 1'b1;
    wr(2'd0, 8'h02);
    rd(2'd0, d); chk("R8 request alone", d, 8'h05);
    init_ack = 1'b1;
    tick();
    rd(2'd0, d); chk("R8 forced", d, 8'h07);
    wr(2'd0, 8'h07);
    rd(2'd0, d); chk("R8 write ignored", d, 8'h07);
    init_req = 1'b0; init_ack = 1'b0;
    tick();
  endtask

  task automatic t_collide();
    logic [7:0] d;
    eng_sent = 3'b001;
    wr(2'd0, 8'h01);
    eng_sent = '0;
    rd(2'd0, d); chk("R11 set wins", d, 8'h07);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_clear();
    t_irq();
    t_sent();
    t_abort();
    t_stray_abort();
    t_listen();
    t_init();
    t_collide();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule